// File: doc/BRIEF.md
# Single-Channel PWM Output Generator

This block drives one pulse-width-modulated pin from whichever of four shared timer counters it is told to follow. The output rises when the followed counter equals a programmed high point. It falls when the counter reaches a low point, which is the high point plus the integer part of a duty value, wrapped to the counter's current resolution. While the channel is disabled, the pin holds a programmable idle level instead.

Software writes configuration into shadow registers through a small word-addressed write port. The shadow values reach the comparator only when an update strobe is written, so a reconfiguration never leaves a half-applied state in the active copy. The duty value has an extra arm bit so that a commit can leave the running duty alone.

The block also counts wraps of the followed timer. After a programmed number of wraps it raises a sticky interrupt.

Top module: `pwmch_top`

## Requirements
- R1: After synchronous reset, `pwm_o` and `irq_o` are low, the active timer select is 0, the output is disabled, the idle level is low and every shadow and active field is zero.
- R2: The active 2-bit timer select (CTRL bits 1:0, value k selects timer k) picks the counter, resolution and wrap pulse used by the channel. Counters and wrap pulses of the other timers have no effect on `pwm_o` or `irq_o`.
- R3: With the output enabled, `pwm_o` goes high on the clock edge that samples the selected counter equal to the 20-bit active high point (HIGH register, address 1, bits 19:0). The new value is visible after that edge.
- R4: With the output enabled, `pwm_o` goes low on the edge that samples the selected counter equal to the low point. The low point is (high point + active duty bits 24:4) truncated to 20 bits and masked to the resolution. The duty is held in the DUTY register, address 2, bits 24:0, whose low 4 bits are fraction. When both points match in the same cycle, low wins.
- R5: The low point is masked to the selected timer's resolution r: only bits below r are kept, so an r of 6 wraps the low point modulo 64.
- R6: While the active output-enable bit (CTRL bit 2) is 0, `pwm_o` takes the idle level (CTRL bit 3) one edge later. The idle level applies as soon as it is written, without an update.
- R7: Writing CTRL with bit 4 set copies the shadow timer select, output enable, overflow enable (CTRL bit 15) and high point into the active set on the following edge. Shadow writes without that bit leave the active set unchanged.
- R8: The shadow duty reaches the active set only on a commit while the arm flag (address 3, bit 0) is set. A commit clears the arm flag, and a commit without the flag leaves the active duty unchanged.
- R9: With overflow counting enabled, `irq_o` rises on the edge that samples the (L+1)-th selected wrap pulse, where L is CTRL bits 14:5. L applies immediately.
- R10: `irq_o` stays high until a CTRL write with bit 17 set clears it. The wrap count restarts from zero when the interrupt fires.
- R11: A CTRL write with bit 16 set clears the wrap count, so the next interrupt needs L+1 further pulses.
- R12: While overflow counting is disabled, wrap pulses neither advance the count nor raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Word address: 0 CTRL, 1 HIGH, 2 DUTY, 3 ARM |
| wr_data | input | 32 | Write data |
| tmr_cnt | input | NUM_TMR*CNT_W (80) | Packed counters, timer k in bits k*CNT_W upward |
| tmr_res | input | NUM_TMR*RES_W (20) | Packed counter resolutions, timer k in bits k*RES_W upward |
| tmr_ovf | input | NUM_TMR (4) | One-cycle wrap pulse per timer |
| pwm_o | output | 1 | Registered PWM output |
| irq_o | output | 1 | Sticky overflow-count interrupt |

## Verification
The bench builds the block with its default parameters: four timers, 20-bit counters, a 25-bit duty with 4 fraction bits and a 10-bit wrap limit. The bench drives counter values and resolutions directly instead of running real timers. This lets it place the counter on the high point, the low point, a low point wrapped by a narrow resolution, and a coincident high and low point, each in a chosen cycle. A small wrap limit of 2 keeps the interrupt paths (firing, clearing, restart and counter reset) to a few pulses each.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_HIGH = 2'd1,
    REG_DUTY = 2'd2,
    REG_ARM  = 2'd3
  } reg_sel_e;

  // CTRL word bit positions
  localparam int B_TSEL = 0;
  localparam int B_OEN  = 2;
  localparam int B_IDLE = 3;
  localparam int B_UPD  = 4;
  localparam int B_LIM  = 5;
  localparam int B_OVEN = 15;
  localparam int B_OCLR = 16;
  localparam int B_ICLR = 17;
  // ARM word bit position
  localparam int B_ARM  = 0;

endpackage

// File: rtl/pwmch_cfg.sv
module pwmch_cfg
  import pwmch_pkg::*;
#(
  parameter int SEL_W  = 2,
  parameter int CNT_W  = 20,
  parameter int DUTY_W = 25,
  parameter int OVF_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  act_sel,
  output logic              act_oen,
  output logic              act_oven,
  output logic [CNT_W-1:0]  act_high,
  output logic [DUTY_W-1:0] act_duty,
  output logic              idle_lvl,
  output logic [OVF_W-1:0]  ovf_lim,
  output logic              ovf_clr,
  output logic              irq_ack
);

  logic [SEL_W-1:0]  shd_sel;
  logic              shd_oen;
  logic              shd_oven;
  logic [CNT_W-1:0]  shd_high;
  logic [DUTY_W-1:0] shd_duty;
  logic              arm_q;
  logic              upd_q;

  logic wr_ctrl, wr_high, wr_duty, wr_arm;
  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
  assign wr_high = wr_en && (wr_addr == REG_HIGH);
  assign wr_duty = wr_en && (wr_addr == REG_DUTY);
  assign wr_arm  = wr_en && (wr_addr == REG_ARM);

  assign ovf_clr = wr_ctrl && wr_data[B_OCLR];
  assign irq_ack = wr_ctrl && wr_data[B_ICLR];

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:DUTY_W];

  // shadow side and immediate fields
  always_ff @(posedge clk) begin
    if (rst) begin
      shd_sel  <= '0;
      shd_oen  <= 1'b0;
      shd_oven <= 1'b0;
      shd_high <= '0;
      shd_duty <= '0;
      idle_lvl <= 1'b0;
      ovf_lim  <= '0;
      upd_q    <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (wr_ctrl) begin
        shd_sel  <= wr_data[B_TSEL +: SEL_W];
        shd_oen  <= wr_data[B_OEN];
        shd_oven <= wr_data[B_OVEN];
        idle_lvl <= wr_data[B_IDLE];
        ovf_lim  <= wr_data[B_LIM +: OVF_W];
        upd_q    <= wr_data[B_UPD];
      end
      if (wr_high) shd_high <= wr_data[CNT_W-1:0];
      if (wr_duty) shd_duty <= wr_data[DUTY_W-1:0];
    end
  end

  // active side: commit one edge after the strobe write
  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel  <= '0;
      act_oen  <= 1'b0;
      act_oven <= 1'b0;
      act_high <= '0;
      act_duty <= '0;
      arm_q    <= 1'b0;
    end else begin
      if (upd_q) begin
        act_sel  <= shd_sel;
        act_oen  <= shd_oen;
        act_oven <= shd_oven;
        act_high <= shd_high;
        if (arm_q) begin
          act_duty <= shd_duty;
          arm_q    <= 1'b0;
        end
      end
      if (wr_arm && wr_data[B_ARM]) arm_q <= 1'b1;
    end
  end

  p_commit_r7: assert property (@(posedge clk) disable iff (rst)
    upd_q |=> (act_high == $past(shd_high)) && (act_sel == $past(shd_sel)));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !upd_q |=> $stable(act_high) && $stable(act_sel) && $stable(act_oen));

  p_unarmed_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_q && !arm_q) |=> $stable(act_duty));

endmodule

// File: rtl/pwmch_cmp.sv
module pwmch_cmp #(
  parameter int CNT_W  = 20,
  parameter int DUTY_W = 25,
  parameter int FRAC_W = 4,
  parameter int RES_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic [CNT_W-1:0]  high_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              oen_i,
  input  logic              idle_i,
  output logic              pwm_o
);

  localparam int TOP = FRAC_W + CNT_W;

  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] duty_int;
  logic [CNT_W-1:0] lo_pt;
  logic             hit_hi, hit_lo;
  logic             pwm_q;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(res_i));
  end

  assign duty_int = duty_i[FRAC_W +: CNT_W];
  assign lo_pt    = (high_i + duty_int) & mask;
  assign hit_hi   = (cnt_i == high_i);
  assign hit_lo   = (cnt_i == lo_pt);

  generate
    if (TOP < DUTY_W) begin : g_sink_top
      logic unused_top;
      assign unused_top = ^duty_i[DUTY_W-1:TOP];
    end
    if (FRAC_W > 0) begin : g_sink_frac
      logic unused_frac;
      assign unused_frac = ^duty_i[FRAC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          pwm_q <= 1'b0;
    else if (!oen_i)  pwm_q <= idle_i;
    else if (hit_lo)  pwm_q <= 1'b0;
    else if (hit_hi)  pwm_q <= 1'b1;
  end

  assign pwm_o = pwm_q;

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !oen_i |=> (pwm_q == $past(idle_i)));

  p_set_r3: assert property (@(posedge clk) disable iff (rst)
    (oen_i && (cnt_i == high_i) && (cnt_i != lo_pt)) |=> pwm_q);

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (oen_i && (cnt_i == lo_pt)) |=> !pwm_q);

endmodule

// File: rtl/pwmch_ovf.sv
module pwmch_ovf #(
  parameter int OVF_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_i,
  input  logic             en_i,
  input  logic [OVF_W-1:0] lim_i,
  input  logic             clr_i,
  input  logic             ack_i,
  output logic             irq_o
);

  logic [OVF_W-1:0] cnt_q;
  logic             irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (ack_i) irq_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (pulse_i && en_i) begin
        if (cnt_q == lim_i) begin
          cnt_q <= '0;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign irq_o = irq_q;

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(pulse_i && en_i));

  p_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !pulse_i) |=> !irq_q);

  p_reset_cnt_r11: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));

  p_disabled_r12: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwmch_top.sv
module pwmch_top #(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 20,
  parameter int DUTY_W  = 25,
  parameter int FRAC_W  = 4,
  parameter int OVF_W   = 10,
  parameter int DATA_W  = 32,
  parameter int RES_W   = $clog2(CNT_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [NUM_TMR*CNT_W-1:0] tmr_cnt,
  input  logic [NUM_TMR*RES_W-1:0] tmr_res,
  input  logic [NUM_TMR-1:0]       tmr_ovf,
  output logic                     pwm_o,
  output logic                     irq_o
);

  localparam int SEL_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

  logic [SEL_W-1:0]  act_sel;
  logic              act_oen, act_oven, idle_lvl, ovf_clr, irq_ack;
  logic [CNT_W-1:0]  act_high;
  logic [DUTY_W-1:0] act_duty;
  logic [OVF_W-1:0]  ovf_lim;

  logic [CNT_W-1:0] cnt_a [NUM_TMR];
  logic [RES_W-1:0] res_a [NUM_TMR];

  genvar g;
  generate
    for (g = 0; g < NUM_TMR; g++) begin : g_tmr
      assign cnt_a[g] = tmr_cnt[g*CNT_W +: CNT_W];
      assign res_a[g] = tmr_res[g*RES_W +: RES_W];
    end
  endgenerate

  logic [CNT_W-1:0] sel_cnt;
  logic [RES_W-1:0] sel_res;
  logic             sel_ovf;
  assign sel_cnt = cnt_a[act_sel];
  assign sel_res = res_a[act_sel];
  assign sel_ovf = tmr_ovf[act_sel];

  pwmch_cfg #(
    .SEL_W(SEL_W), .CNT_W(CNT_W), .DUTY_W(DUTY_W), .OVF_W(OVF_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .act_sel(act_sel), .act_oen(act_oen), .act_oven(act_oven),
    .act_high(act_high), .act_duty(act_duty), .idle_lvl(idle_lvl),
    .ovf_lim(ovf_lim), .ovf_clr(ovf_clr), .irq_ack(irq_ack)
  );

  pwmch_cmp #(
    .CNT_W(CNT_W), .DUTY_W(DUTY_W), .FRAC_W(FRAC_W), .RES_W(RES_W)
  ) u_cmp (
    .clk(clk), .rst(rst), .cnt_i(sel_cnt), .res_i(sel_res),
    .high_i(act_high), .duty_i(act_duty), .oen_i(act_oen), .idle_i(idle_lvl),
    .pwm_o(pwm_o)
  );

  pwmch_ovf #(.OVF_W(OVF_W)) u_ovf (
    .clk(clk), .rst(rst), .pulse_i(sel_ovf), .en_i(act_oven), .lim_i(ovf_lim),
    .clr_i(ovf_clr), .ack_i(irq_ack), .irq_o(irq_o)
  );

  p_reset_r1: assert property (@(posedge clk) rst |=> (!pwm_o && !irq_o));

endmodule

// File: tb/tb_pwmch_top.sv
module tb_pwmch_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4, CW = 20, RW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NT*CW-1:0] tmr_cnt = '0;
  logic [NT*RW-1:0] tmr_res = {NT{5'd20}};
  logic [NT-1:0] tmr_ovf = '0;
  logic pwm_o, irq_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmch_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr_cnt(tmr_cnt), .tmr_res(tmr_res), .tmr_ovf(tmr_ovf),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(input int tsel, input bit oen, input bit idle,
      input bit upd, input int lim, input bit oven, input bit oclr, input bit iclr);
    logic [31:0] w = '0;
    w[1:0] = tsel[1:0]; w[2] = oen; w[3] = idle; w[4] = upd;
    w[14:5] = lim[9:0]; w[15] = oven; w[16] = oclr; w[17] = iclr;
    return w;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic commit(input logic [31:0] c);
    wr(2'd0, c | 32'h10);
    @(negedge clk);
  endtask

  task automatic drive(input int idx, input int v);
    tmr_cnt[idx*CW +: CW] = v[CW-1:0];
    @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); tmr_ovf[idx] = 1'b1;
    @(negedge clk); tmr_ovf = '0;
  endtask

  task automatic t_reset;
    chk("R1 pwm after reset", pwm_o, 1'b0);
    chk("R1 irq after reset", irq_o, 1'b0);
    drive(0, 0);
    chk("R1 output disabled idle low at counter 0", pwm_o, 1'b0);
  endtask

  task automatic t_basic;
    wr(2'd1, 32'd10); wr(2'd2, 32'd320); wr(2'd3, 32'd1);
    commit(ctrl(0, 1, 0, 1, 0, 0, 0, 0));
    drive(0, 5);  chk("R3 below high point", pwm_o, 1'b0);
    drive(0, 10); chk("R3 rise at high point", pwm_o, 1'b1);
    drive(0, 25); chk("R3 held between points", pwm_o, 1'b1);
    drive(0, 30); chk("R4 fall at low point", pwm_o, 1'b0);
    drive(0, 31); chk("R4 held low", pwm_o, 1'b0);
  endtask

  task automatic t_idle;
    commit(ctrl(0, 0, 1, 1, 0, 0, 0, 0));
    drive(0, 10); chk("R6 idle level high", pwm_o, 1'b1);
    wr(2'd0, ctrl(0, 0, 0, 0, 0, 0, 0, 0));
    drive(0, 10); chk("R6 idle level low, counter at high point", pwm_o, 1'b0);
  endtask

  task automatic t_select;
    drive(0, 0);
    commit(ctrl(2, 1, 0, 1, 0, 0, 0, 0));
    drive(0, 10); chk("R2 unselected counter ignored", pwm_o, 1'b0);
    drive(2, 10); chk("R2 selected timer2 rises", pwm_o, 1'b1);
    drive(2, 30); chk("R2 selected timer2 falls", pwm_o, 1'b0);
  endtask

  task automatic t_shadow;
    wr(2'd1, 32'd50);
    drive(2, 50); chk("R7 shadow high not active", pwm_o, 1'b0);
    drive(2, 10); chk("R7 old high still active", pwm_o, 1'b1);
    drive(2, 30); chk("R7 old low still active", pwm_o, 1'b0);
    commit(ctrl(2, 1, 0, 1, 0, 0, 0, 0));
    drive(2, 50); chk("R7 committed high point", pwm_o, 1'b1);
    drive(2, 70); chk("R7 committed low point", pwm_o, 1'b0);
  endtask

  task automatic t_arm;
    wr(2'd2, 32'd80);
    commit(ctrl(2, 1, 0, 1, 0, 0, 0, 0));
    drive(2, 50); chk("R8 rise", pwm_o, 1'b1);
    drive(2, 55); chk("R8 unarmed duty not applied", pwm_o, 1'b1);
    drive(2, 70); chk("R8 old duty still applies", pwm_o, 1'b0);
    wr(2'd3, 32'd1);
    commit(ctrl(2, 1, 0, 1, 0, 0, 0, 0));
    drive(2, 50); chk("R8 rise armed", pwm_o, 1'b1);
    drive(2, 55); chk("R8 armed duty applied", pwm_o, 1'b0);
    wr(2'd2, 32'd160);
    commit(ctrl(2, 1, 0, 1, 0, 0, 0, 0));
    drive(2, 50); chk("R8 rise after arm consumed", pwm_o, 1'b1);
    drive(2, 55); chk("R8 arm cleared by commit", pwm_o, 1'b0);
  endtask

  task automatic t_res;
    tmr_res[2*RW +: RW] = 5'd6;
    wr(2'd1, 32'd60); wr(2'd2, 32'd160); wr(2'd3, 32'd1);
    commit(ctrl(2, 1, 0, 1, 0, 0, 0, 0));
    drive(2, 60); chk("R5 rise", pwm_o, 1'b1);
    drive(2, 70); chk("R5 unmasked low point not used", pwm_o, 1'b1);
    drive(2, 6);  chk("R5 masked low point", pwm_o, 1'b0);
    tmr_res[2*RW +: RW] = 5'd20;
    drive(2, 60); chk("R4 rise before zero duty", pwm_o, 1'b1);
    wr(2'd2, 32'd0); wr(2'd3, 32'd1);
    commit(ctrl(2, 1, 0, 1, 0, 0, 0, 0));
    drive(2, 60); chk("R4 low wins on coincident points", pwm_o, 1'b0);
  endtask

  task automatic t_ovf;
    commit(ctrl(2, 1, 0, 1, 2, 1, 0, 0));
    pulse(2); pulse(2);
    chk("R9 no irq after two wraps", irq_o, 1'b0);
    pulse(0);
    chk("R2 unselected wrap ignored", irq_o, 1'b0);
    pulse(2);
    chk("R9 irq after three wraps", irq_o, 1'b1);
    pulse(2);
    chk("R10 irq sticky", irq_o, 1'b1);
    wr(2'd0, ctrl(2, 1, 0, 0, 2, 1, 1, 1));
    chk("R10 irq cleared", irq_o, 1'b0);
    pulse(2); pulse(2);
    chk("R10 restart no early irq", irq_o, 1'b0);
    pulse(2);
    chk("R10 irq after restart", irq_o, 1'b1);
    wr(2'd0, ctrl(2, 1, 0, 0, 2, 1, 0, 1));
  endtask

  task automatic t_oclr;
    pulse(2); pulse(2);
    wr(2'd0, ctrl(2, 1, 0, 0, 2, 1, 1, 0));
    pulse(2); pulse(2);
    chk("R11 count reset delays irq", irq_o, 1'b0);
    pulse(2);
    chk("R11 irq after fresh count", irq_o, 1'b1);
    wr(2'd0, ctrl(2, 1, 0, 0, 2, 1, 1, 1));
  endtask

  task automatic t_disabled;
    commit(ctrl(2, 1, 0, 1, 2, 0, 0, 0));
    pulse(2); pulse(2); pulse(2); pulse(2);
    chk("R12 disabled counting no irq", irq_o, 1'b0);
    commit(ctrl(2, 1, 0, 1, 2, 1, 0, 0));
    pulse(2); pulse(2);
    chk("R12 count did not advance while disabled", irq_o, 1'b0);
    pulse(2);
    chk("R12 irq after re-enable", irq_o, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_basic;
    t_idle;
    t_select;
    t_shadow;
    t_arm;
    t_res;
    t_ovf;
    t_oclr;
    t_disabled;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule